// File: doc/BRIEF.md
# Keyed Configuration-Space Unlock Sequencer

This block protects a small configuration register file that sits behind an index/data port pair in host I/O space. After reset the register file is locked. The host opens it by writing a fixed four-byte key to the index port. The last byte of that key depends on which of two base ports the device has been strapped to. Once the space is open, the host writes a register number to the index port and then reads or writes the selected register through the data port.

The register file holds three read-only identity bytes (two identification bytes and a revision byte) and a logical-device selector. It also holds a flash-segment control byte. A two-byte flash I/O base address is visible only while logical device 7 is selected. The host closes the space with an ordinary data write of 0x02 to register 0x02, so no key is needed to leave. A strap input picks the base port: 0x2E or 0x4E. The data port is always the base address plus one.

Reads are registered. A read strobe in one cycle updates the read data output at that clock edge, and the value holds until the next read strobe.

Top module: `cfgkey_gate`

## Requirements
- R1: While locked, index-port writes of 0x87, 0x01, 0x55 and then a fourth byte open the space. The fourth byte must be 0x55 when portSel=0 (base 0x2E) and 0xAA when portSel=1 (base 0x4E). Any other fourth byte leaves the space locked.
- R2: A wrong byte during key entry returns the matcher to idle. If that wrong byte is 0x87, matching restarts as though the first key byte had just been accepted.
- R3: While locked, data-port writes change no register. Every read returns 0xFF. rdData takes its new value at the clock edge where rdEn is high and holds it until the next read.
- R4: The index port is the strapped base address and the data port is base+1. Accesses to any other address change nothing and read as 0xFF. In the open state the index value persists until the index port is written again, and an index-port read returns it.
- R5: Registers 0x20, 0x21 and 0x22 read 0x87, 0x16 and 0x01 (the identification high byte, low byte and revision). Writes to them are ignored.
- R6: Register 0x07 is a read/write logical-device selector.
- R7: Register 0x24 is the flash-segment control byte: bit 0 suspend, bits 1-3 segment enables, bit 4 host write enable, bit 5 chip-select pin choice. Bits 5:0 are read/write, and bits 7:6 read as zero.
- R8: While register 0x07 holds 7, registers 0x64 and 0x65 hold the high and low bytes of the flash base address. Bits 2:0 of the low byte always read zero. While any other device is selected, these two registers read 0xFF and ignore writes.
- R9: Writing 0x02 to register 0x02 locks the space again. Writing any other value to register 0x02 leaves it open.
- R10: After reset the space is locked, the index and the device selector are 0x00, the segment control byte is 0x00 and the flash base is 0x0820. These values survive a lock/unlock cycle.
- R11: In the open state, unmapped registers read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portSel | input | 1 | Base-port strap: 0 selects 0x2E, 1 selects 0x4E |
| ioAddr | input | 16 | Host I/O address of the current access |
| wrEn | input | 1 | Host write strobe, one cycle per write |
| wrData | input | 8 | Host write data |
| rdEn | input | 1 | Host read strobe, one cycle per read |
| rdData | output | 8 | Registered read data |
| cfgOpen | output | 1 | High while the configuration space is unlocked |

## Verification
The assertions check the following on every cycle:
- Every read in the locked state returns 0xFF.
- The space opens only on the clock edge right after an index-port write.
- The exit write always locks the space.
- The index changes only on an index-port write.
- The device selector stays fixed while locked.
- The identification read and the low flash base byte read return legal values.

Only the bench scenarios can show the ordering behaviour of the key matcher:
- the restart on a repeated 0x87;
- rejection of the wrong strap's fourth byte;
- that register values survive a relock.

The same applies to gating of the flash base by the selected device, the masking of read-only bits, and base-port selection after re-strapping.

// File: rtl/cfgkey_pkg.sv
package cfgkey_pkg;

  typedef enum logic [2:0] {
    K_IDLE = 3'd0,
    K_GOT1 = 3'd1,
    K_GOT2 = 3'd2,
    K_GOT3 = 3'd3,
    K_OPEN = 3'd4
  } keyState_t;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_IDX  = 2'd1,
    RD_REG  = 2'd2
  } rdSel_t;

  typedef struct packed {
    logic   idxWr;
    logic   regWr;
    logic   rdStrobe;
    rdSel_t rdSel;
  } cfgStrobe_t;

  localparam logic [7:0] REG_EXIT    = 8'h02;
  localparam logic [7:0] REG_LDN     = 8'h07;
  localparam logic [7:0] REG_ID_HI   = 8'h20;
  localparam logic [7:0] REG_ID_LO   = 8'h21;
  localparam logic [7:0] REG_REV     = 8'h22;
  localparam logic [7:0] REG_SEG     = 8'h24;
  localparam logic [7:0] REG_BASE_HI = 8'h64;
  localparam logic [7:0] REG_BASE_LO = 8'h65;
  localparam logic [7:0] EXIT_VALUE  = 8'h02;

endpackage

// File: rtl/cfgkey_ctrl.sv
module cfgkey_ctrl
  import cfgkey_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] PORT_A   = 16'h002E,
  parameter logic [15:0] PORT_B   = 16'h004E,
  parameter logic [7:0]  KEY0     = 8'h87,
  parameter logic [7:0]  KEY1     = 8'h01,
  parameter logic [7:0]  KEY2     = 8'h55,
  parameter logic [7:0]  KEY3_A   = 8'h55,
  parameter logic [7:0]  KEY3_B   = 8'hAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portSel,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  input  logic [7:0]        curIndex,
  output cfgStrobe_t        strb,
  output logic              cfgOpen
);

  localparam logic [ADDR_W-1:0] IDX_A  = ADDR_W'(PORT_A);
  localparam logic [ADDR_W-1:0] IDX_B  = ADDR_W'(PORT_B);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(PORT_A + 16'd1);
  localparam logic [ADDR_W-1:0] DATA_B = ADDR_W'(PORT_B + 16'd1);

  keyState_t  state, stateNext;
  logic       idxHit, dataHit;
  logic [7:0] expectByte;

  assign idxHit  = (ioAddr == (portSel ? IDX_B : IDX_A));
  assign dataHit = (ioAddr == (portSel ? DATA_B : DATA_A));
  assign cfgOpen = (state == K_OPEN);

  always_comb begin
    unique case (state)
      K_GOT1:  expectByte = KEY1;
      K_GOT2:  expectByte = KEY2;
      K_GOT3:  expectByte = portSel ? KEY3_B : KEY3_A;
      default: expectByte = KEY0;
    endcase
  end

  always_comb begin
    stateNext = state;
    if (state == K_OPEN) begin
      if (wrEn && dataHit && curIndex == REG_EXIT && wrData == EXIT_VALUE)
        stateNext = K_IDLE;
    end else if (wrEn && idxHit) begin
      if (wrData == expectByte) begin
        unique case (state)
          K_IDLE:  stateNext = K_GOT1;
          K_GOT1:  stateNext = K_GOT2;
          K_GOT2:  stateNext = K_GOT3;
          default: stateNext = K_OPEN;
        endcase
      end else if (wrData == KEY0) begin
        stateNext = K_GOT1;
      end else begin
        stateNext = K_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= K_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb.idxWr    = cfgOpen && wrEn && idxHit;
    strb.regWr    = cfgOpen && wrEn && dataHit;
    strb.rdStrobe = rdEn;
    if (!cfgOpen)     strb.rdSel = RD_NONE;
    else if (dataHit) strb.rdSel = RD_REG;
    else if (idxHit)  strb.rdSel = RD_IDX;
    else              strb.rdSel = RD_NONE;
  end

endmodule

// File: rtl/cfgkey_regs.sv
module cfgkey_regs
  import cfgkey_pkg::*;
#(
  parameter logic [7:0]  ID_HI     = 8'h87,
  parameter logic [7:0]  ID_LO     = 8'h16,
  parameter logic [7:0]  REV_ID    = 8'h01,
  parameter logic [7:0]  FLASH_LDN = 8'h07,
  parameter int          SEG_W     = 6,
  parameter int          ALIGN_B   = 3,
  parameter logic [15:0] BASE_RST  = 16'h0820
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfgStrobe_t strb,
  input  logic [7:0] wrData,
  output logic [7:0] curIndex,
  output logic [7:0] curLdn,
  output logic [7:0] rdData
);

  localparam int LO_W = 8 - ALIGN_B;

  logic [7:0]       indexQ, ldnQ, baseHiQ;
  logic [SEG_W-1:0] segQ;
  logic [LO_W-1:0]  baseLoQ;
  logic [7:0]       regVal;
  logic             flashSel;

  assign flashSel = (ldnQ == FLASH_LDN);
  assign curIndex = indexQ;
  assign curLdn   = ldnQ;

  always_comb begin
    case (indexQ)
      REG_ID_HI:   regVal = ID_HI;
      REG_ID_LO:   regVal = ID_LO;
      REG_REV:     regVal = REV_ID;
      REG_LDN:     regVal = ldnQ;
      REG_SEG:     regVal = 8'(segQ);
      REG_BASE_HI: regVal = flashSel ? baseHiQ : 8'hFF;
      REG_BASE_LO: regVal = flashSel ? {baseLoQ, {ALIGN_B{1'b0}}} : 8'hFF;
      default:     regVal = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      indexQ  <= 8'h00;
      ldnQ    <= 8'h00;
      segQ    <= '0;
      baseHiQ <= BASE_RST[15:8];
      baseLoQ <= BASE_RST[7:ALIGN_B];
    end else begin
      if (strb.idxWr) indexQ <= wrData;
      if (strb.regWr) begin
        case (indexQ)
          REG_LDN: ldnQ <= wrData;
          REG_SEG: segQ <= wrData[SEG_W-1:0];
          REG_BASE_HI: if (flashSel) baseHiQ <= wrData;
          REG_BASE_LO: if (flashSel) baseLoQ <= wrData[7:ALIGN_B];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= 8'hFF;
    else if (strb.rdStrobe) begin
      unique case (strb.rdSel)
        RD_REG:  rdData <= regVal;
        RD_IDX:  rdData <= indexQ;
        default: rdData <= 8'hFF;
      endcase
    end
  end

endmodule

// File: rtl/cfgkey_gate.sv
module cfgkey_gate
  import cfgkey_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter logic [15:0] PORT_A = 16'h002E,
  parameter logic [15:0] PORT_B = 16'h004E,
  parameter logic [7:0]  ID_HI  = 8'h87,
  parameter logic [7:0]  ID_LO  = 8'h16,
  parameter logic [7:0]  REV_ID = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portSel,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  output logic              cfgOpen
);

  cfgStrobe_t strb;
  logic [7:0] curIndex;
  logic [7:0] curLdn;

  cfgkey_ctrl #(
    .ADDR_W(ADDR_W), .PORT_A(PORT_A), .PORT_B(PORT_B)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .portSel(portSel), .ioAddr(ioAddr),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .curIndex(curIndex),
    .strb(strb), .cfgOpen(cfgOpen)
  );

  cfgkey_regs #(
    .ID_HI(ID_HI), .ID_LO(ID_LO), .REV_ID(REV_ID)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .curIndex(curIndex), .curLdn(curLdn), .rdData(rdData)
  );

endmodule

// File: rtl/cfgkey_gate_chk.sv
module cfgkey_gate_chk #(
  parameter int          ADDR_W = 16,
  parameter logic [15:0] PORT_A = 16'h002E,
  parameter logic [15:0] PORT_B = 16'h004E,
  parameter logic [7:0]  ID_HI  = 8'h87
) (
  input logic              clk,
  input logic              rstN,
  input logic              portSel,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              wrEn,
  input logic [7:0]        wrData,
  input logic              rdEn,
  input logic [7:0]        rdData,
  input logic              cfgOpen,
  input logic [7:0]        curIndex,
  input logic [7:0]        curLdn
);

  logic [15:0] basePort;
  logic        onIdx, onData;
  assign basePort = portSel ? PORT_B : PORT_A;
  assign onIdx    = (16'(ioAddr) == basePort);
  assign onData   = (16'(ioAddr) == basePort + 16'd1);

  a_r3_locked_read_ff: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !cfgOpen) |=> rdData == 8'hFF);

  a_r3_locked_ldn_stable: assert property (@(posedge clk) disable iff (!rstN)
    !cfgOpen |=> $stable(curLdn));

  a_r1_open_after_index_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgOpen) |-> $past(wrEn && onIdx));

  a_r9_exit_write_locks: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOpen && wrEn && onData && curIndex == 8'h02 && wrData == 8'h02) |=> !cfgOpen);

  a_r4_index_persists: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && onIdx) |=> $stable(curIndex));

  a_r5_id_high_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && cfgOpen && onData && curIndex == 8'h20) |=> rdData == ID_HI);

  a_r8_base_low_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && cfgOpen && onData && curIndex == 8'h65 && curLdn == 8'h07)
      |=> rdData[2:0] == 3'b000);

endmodule

bind cfgkey_gate cfgkey_gate_chk #(
  .ADDR_W(ADDR_W), .PORT_A(PORT_A), .PORT_B(PORT_B), .ID_HI(ID_HI)
) u_chk (
  .clk(clk), .rstN(rstN), .portSel(portSel), .ioAddr(ioAddr),
  .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
  .cfgOpen(cfgOpen), .curIndex(curIndex), .curLdn(curLdn)
);

// File: tb/cfgkey_gate_bench.sv
`timescale 1ns/1ps
module cfgkey_gate_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        portSel = 1'b0;
  logic [15:0] ioAddr = 16'h0000;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic        cfgOpen;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  cfgkey_gate u_cfgkey_gate (
    .clk(clk), .rstN(rstN), .portSel(portSel), .ioAddr(ioAddr),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .cfgOpen(cfgOpen)
  );

  function automatic logic [15:0] idxPort();
    return portSel ? 16'h004E : 16'h002E;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdExpect(input logic [15:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    ioAddr = a; rdEn = 1'b1;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic key(input logic [7:0] last);
    wr(idxPort(), 8'h87); wr(idxPort(), 8'h01);
    wr(idxPort(), 8'h55); wr(idxPort(), last);
  endtask

  task automatic regWr(input logic [7:0] r, input logic [7:0] d);
    wr(idxPort(), r); wr(idxPort() + 16'd1, d);
  endtask

  task automatic regRd(input logic [7:0] r, input logic [7:0] e, input string tag);
    wr(idxPort(), r); rdExpect(idxPort() + 16'd1, e, tag);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  // monitor: pops the scoreboard after each read edge
  initial begin
    forever begin
      @(posedge clk);
      if (rdEn && rstN) begin
        #2;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL unexpected read, actual %02h expected none", rdData);
        end else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front(); t = tagQ.pop_front();
          checks++;
          if (rdData !== e) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", t, rdData, e);
          end
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    // R10 / R3: locked after reset
    rdExpect(16'h002F, 8'hFF, "R10 locked data read after reset");
    rdExpect(16'h002E, 8'hFF, "R3 locked index read");
    // R3: locked data write attempt to ldn (index stays 0 while locked)
    wr(16'h002F, 8'h05);
    // R1: wrong fourth byte for strap 0
    key(8'hAA);
    rdExpect(16'h002F, 8'hFF, "R1 wrong fourth byte stays locked");
    // R2: restart on 0x87 mid-key
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h87);
    wr(16'h002E, 8'h01); wr(16'h002E, 8'h55); wr(16'h002E, 8'h55);
    rdExpect(16'h002E, 8'h00, "R2 restart opens, R10 index zero");
    regRd(8'h07, 8'h00, "R3 locked write ignored, R10 ldn zero");
    regRd(8'h24, 8'h00, "R10 segment reset");
    regRd(8'h20, 8'h87, "R5 id high");
    regRd(8'h21, 8'h16, "R5 id low");
    regRd(8'h22, 8'h01, "R5 revision");
    regWr(8'h20, 8'h33);
    rdExpect(16'h002F, 8'h87, "R5 id write ignored");
    // R6 / R8
    regWr(8'h07, 8'h05);
    rdExpect(16'h002F, 8'h05, "R6 ldn readback");
    regRd(8'h64, 8'hFF, "R8 base hidden other ldn");
    regWr(8'h64, 8'h11);
    regWr(8'h07, 8'h07);
    regRd(8'h64, 8'h08, "R8 base hi reset value write ignored");
    regRd(8'h65, 8'h20, "R8 base lo reset value");
    regWr(8'h65, 8'h3F);
    rdExpect(16'h002F, 8'h38, "R8 base lo aligned");
    regWr(8'h64, 8'h0A);
    rdExpect(16'h002F, 8'h0A, "R8 base hi write");
    // R7
    regWr(8'h24, 8'hFF);
    rdExpect(16'h002F, 8'h3F, "R7 segment top bits zero");
    // R4: other addresses
    wr(16'h0030, 8'h99);
    wr(16'h004E, 8'h99);
    rdExpect(16'h002E, 8'h24, "R4 index persists");
    rdExpect(16'h0030, 8'hFF, "R4 other address reads ff");
    rdExpect(16'h002F, 8'h3F, "R4 other writes no effect");
    // R11
    regRd(8'h30, 8'h00, "R11 unmapped reads zero");
    // R9
    regWr(8'h02, 8'h01);
    regRd(8'h20, 8'h87, "R9 other value keeps open");
    regWr(8'h02, 8'h02);
    rdExpect(16'h002F, 8'hFF, "R9 exit locks data");
    rdExpect(16'h002E, 8'hFF, "R9 exit locks index");
    wr(16'h002F, 8'h00);
    // re-entry keeps state
    key(8'h55);
    regRd(8'h24, 8'h3F, "R10 segment survives relock");
    regRd(8'h64, 8'h0A, "R10 base survives relock");

    // strap 1
    portSel = 1'b1;
    doReset();
    key(8'h55);
    rdExpect(16'h004F, 8'hFF, "R1 strap1 rejects 0x55");
    key(8'hAA);
    rdExpect(16'h002F, 8'hFF, "R4 old port inactive under strap1");
    regRd(8'h20, 8'h87, "R1 strap1 opens with 0xAA");
    regRd(8'h24, 8'h00, "R10 segment reset again");

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard actual %0d pending expected 0", expQ.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule